// File: doc/BRIEF.md
# Width-Packing Card Data FIFO

This block carries the data phase of a card transfer between a CPU register port and a byte-wide card data path. It keeps two 32-byte circular buffers, one per direction. A CPU access moves 1, 2 or 4 bytes. Bytes are packed into the access, or taken out of it, with the earliest byte in the highest lane that the access uses. On the card side, a valid/ready handshake moves at most one byte per clock.

A start strobe captures the direction and loads a remaining-byte counter with block count times block length. The counter decrements on every card-side byte. When it reaches zero the transfer ends and the block raises a data-done pulse. A transfer toward the card also raises a program-done pulse. Service request flags tell the CPU when to drain the receive side or refill the transmit side. A flush strobe drops whatever the transmit buffer holds.

Top module: `data_pack_fifo`

## Requirements
- R1: After reset, busy, rx_req, tx_req, data_done, prog_done, card_tx_valid and card_rx_ready are all low.
- R2: A start pulse sets busy, empties both buffers, latches dir_wr (1 = toward the card), and loads the byte counter with blk_cnt*blk_len. A product of zero ends the transfer on the next clock.
- R3: In the read direction, card_rx_ready is high only while busy, the counter is nonzero and the receive buffer holds fewer than 32 bytes.
- R4: A CPU read takes min(access width, bytes held) bytes. Width codes on cpu_size are: 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. The first byte taken appears in lane (width-1), so bits [8*width-1 -: 8], and later bytes appear in successively lower lanes. Lanes that get no byte read as zero.
- R5: In the write direction, card_tx_valid is high only while busy, the counter is nonzero and the transmit buffer is not empty. Bytes leave in the order they were stored.
- R6: A CPU write stores lane (width-1) first, then the lower lanes. It stops storing once the transmit buffer holds 32 bytes, and the surplus bytes are dropped.
- R7: rx_req is set by each byte accepted from the card and is cleared by a CPU read. If both happen in the same cycle, the accepted byte keeps rx_req set.
- R8: tx_req is high while a write-direction transfer is busy with bytes outstanding. It is low in the cycle after any CPU write.
- R9: When the counter is zero while busy, busy drops and data_done pulses for one cycle. prog_done pulses together with data_done only for a write-direction transfer.
- R10: A pulse on tx_flush discards every byte held in the transmit buffer.
- R11: At most one card byte moves per clock, and each moved byte lowers the counter by exactly one. Both buffers wrap around past index 31 without losing order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer |
| dir_wr | input | 1 | Direction latched at start: 1 toward card, 0 from card |
| blk_len | input | 12 | Block length in bytes |
| blk_cnt | input | 16 | Number of blocks |
| cpu_rd | input | 1 | CPU read of the receive port |
| cpu_wr | input | 1 | CPU write of the transmit port |
| cpu_size | input | 2 | Access width code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data, valid in the cycle cpu_rd is high |
| tx_flush | input | 1 | Discard the transmit buffer contents |
| card_tx_data | output | 8 | Byte toward the card |
| card_tx_valid | output | 1 | Byte toward the card is available |
| card_tx_ready | input | 1 | Card takes the byte |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_ready | output | 1 | Block accepts the byte |
| rx_req | output | 1 | Receive service request |
| tx_req | output | 1 | Transmit service request |
| data_done | output | 1 | One-cycle pulse at transfer end |
| prog_done | output | 1 | One-cycle pulse at the end of a write-direction transfer |
| busy | output | 1 | A transfer is in progress |

## Verification
The receive path is read with a mix of 4-, 2- and 1-byte accesses over a known byte sequence, and a final 4-byte access finds only one byte left. This separates lane ordering from zero fill. A 40-byte read transfer fills the buffer, holds the card off while it is full, and then wraps the indices, which shows whether backpressure and wrap preserve order. On the transmit side, mixed-width writes are popped byte by byte to expose the unpacking order. A write past 32 bytes and a flush followed by a single byte show which bytes really remain. A zero-length start and a count of two blocks of three bytes confirm the multiply and the end-of-transfer timing in both directions.

// File: rtl/data_pack_fifo.sv
module data_pack_fifo #(
  parameter int DEPTH = 32,
  parameter int LEN_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_wr,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [CNT_W-1:0] blk_cnt,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  input  logic [1:0]       cpu_size,
  input  logic [31:0]      cpu_wdata,
  output logic [31:0]      cpu_rdata,
  input  logic             tx_flush,
  output logic [7:0]       card_tx_data,
  output logic             card_tx_valid,
  input  logic             card_tx_ready,
  input  logic [7:0]       card_rx_data,
  input  logic             card_rx_valid,
  output logic             card_rx_ready,
  output logic             rx_req,
  output logic             tx_req,
  output logic             data_done,
  output logic             prog_done,
  output logic             busy
);
  localparam int PW = $clog2(DEPTH);
  localparam int OW = PW + 1;
  localparam int RW = LEN_W + CNT_W;

  logic [7:0]    rx_mem [DEPTH];
  logic [7:0]    tx_mem [DEPTH];
  logic [PW-1:0] rx_head, tx_head;
  logic [OW-1:0] rx_cnt, tx_cnt;
  logic [RW-1:0] rem;
  logic          dir_q;

  logic [2:0]    nb;
  logic [2:0]    rx_take, tx_store;
  logic [OW-1:0] tx_room;
  logic          rx_fire, tx_fire, done_evt, rem_nz;

  assign nb       = (cpu_size == 2'd0) ? 3'd1 : (cpu_size == 2'd1) ? 3'd2 : 3'd4;
  assign rem_nz   = (rem != '0);
  assign rx_take  = (rx_cnt < OW'(nb)) ? rx_cnt[2:0] : nb;
  assign tx_room  = OW'(DEPTH) - tx_cnt;
  assign tx_store = (tx_room < OW'(nb)) ? tx_room[2:0] : nb;

  assign card_rx_ready = busy & ~dir_q & rem_nz & (rx_cnt < OW'(DEPTH));
  assign card_tx_valid = busy & dir_q & rem_nz & (tx_cnt != '0);
  assign card_tx_data  = tx_mem[tx_head];
  assign rx_fire       = card_rx_valid & card_rx_ready;
  assign tx_fire       = card_tx_valid & card_tx_ready;
  assign done_evt      = busy & ~rem_nz;

  always_comb begin
    cpu_rdata = '0;
    for (int i = 0; i < 4; i++) begin
      if (3'(i) < rx_take)
        cpu_rdata[8*(int'(nb)-1-i) +: 8] = rx_mem[rx_head + PW'(i)];
    end
  end

  always_ff @(posedge clk) begin
    if (!start && rx_fire)
      rx_mem[rx_head + rx_cnt[PW-1:0]] <= card_rx_data;
    for (int i = 0; i < 4; i++) begin
      if (!start && !tx_flush && cpu_wr && 3'(i) < tx_store)
        tx_mem[tx_head + tx_cnt[PW-1:0] + PW'(i)] <= cpu_wdata[8*(int'(nb)-1-i) +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; dir_q <= 1'b0; rem <= '0;
      rx_head <= '0; rx_cnt <= '0; tx_head <= '0; tx_cnt <= '0;
      rx_req <= 1'b0; tx_req <= 1'b0; data_done <= 1'b0; prog_done <= 1'b0;
    end else begin
      data_done <= 1'b0;
      prog_done <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        dir_q   <= dir_wr;
        rem     <= RW'(blk_cnt) * RW'(blk_len);
        rx_cnt  <= '0;
        tx_cnt  <= '0;
        rx_req  <= 1'b0;
        tx_req  <= 1'b0;
      end else begin
        if (done_evt) begin
          busy      <= 1'b0;
          data_done <= 1'b1;
          prog_done <= dir_q;
        end
        if (rx_fire || tx_fire) rem <= rem - RW'(1);
        rx_head <= rx_head + (cpu_rd ? PW'(rx_take) : '0);
        rx_cnt  <= rx_cnt - (cpu_rd ? OW'(rx_take) : '0) + OW'(rx_fire);
        tx_head <= tx_head + PW'(tx_fire);
        if (tx_flush) tx_cnt <= '0;
        else          tx_cnt <= tx_cnt + (cpu_wr ? OW'(tx_store) : '0) - OW'(tx_fire);
        if (rx_fire)     rx_req <= 1'b1;
        else if (cpu_rd) rx_req <= 1'b0;
        tx_req <= ~cpu_wr & busy & dir_q & rem_nz;
      end
    end
  end
endmodule

// File: rtl/data_pack_fifo_chk.sv
module data_pack_fifo_chk #(
  parameter int DEPTH = 32,
  parameter int OW    = 6,
  parameter int RW    = 28
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic [RW-1:0] rem,
  input logic [OW-1:0] rx_cnt,
  input logic [OW-1:0] tx_cnt,
  input logic          card_tx_valid,
  input logic          card_tx_ready,
  input logic          card_rx_valid,
  input logic          card_rx_ready,
  input logic          data_done,
  input logic          prog_done
);
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= OW'(DEPTH)); // R3
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= OW'(DEPTH)); // R6
  AST_READY_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    card_rx_ready |-> (busy && rx_cnt < OW'(DEPTH))); // R3
  AST_VALID_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    card_tx_valid |-> (busy && tx_cnt != '0)); // R5
  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_tx_valid && card_rx_ready)); // R11
  AST_REM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && ((card_tx_valid && card_tx_ready) || (card_rx_valid && card_rx_ready)))
      |=> rem == $past(rem) - RW'(1)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) data_done |=> !data_done); // R9
  AST_PROG_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n) prog_done |-> data_done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) data_done |-> !busy); // R9
endmodule

bind data_pack_fifo data_pack_fifo_chk #(.DEPTH(DEPTH), .OW(OW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .rem(rem),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
  .card_tx_valid(card_tx_valid), .card_tx_ready(card_tx_ready),
  .card_rx_valid(card_rx_valid), .card_rx_ready(card_rx_ready),
  .data_done(data_done), .prog_done(prog_done)
);

// File: tb/data_pack_fifo_bench.sv
module data_pack_fifo_bench;
  logic clk = 0, rst_n = 0;
  logic start = 0, dir_wr = 0, cpu_rd = 0, cpu_wr = 0, tx_flush = 0;
  logic [11:0] blk_len = 0;
  logic [15:0] blk_cnt = 0;
  logic [1:0]  cpu_size = 0;
  logic [31:0] cpu_wdata = 0, cpu_rdata;
  logic [7:0]  card_tx_data, card_rx_data = 0;
  logic card_tx_valid, card_tx_ready = 0, card_rx_valid = 0, card_rx_ready;
  logic rx_req, tx_req, data_done, prog_done, busy;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  data_pack_fifo u_data_pack_fifo (.*);

  // width code, expected read data
  localparam logic [33:0] RD_VEC [6] = '{
    {2'd2, 32'h10111213}, {2'd1, 32'h00001415}, {2'd0, 32'h00000016},
    {2'd3, 32'h1718191A}, {2'd2, 32'h1B000000}, {2'd2, 32'h00000000}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic begin_xfer(input logic d, input int len, input int cnt);
    @(negedge clk); start = 1; dir_wr = d; blk_len = 12'(len); blk_cnt = 16'(cnt);
    @(posedge clk); #1 start = 0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); card_rx_valid = 1; card_rx_data = d;
    chk(card_rx_ready === 1'b1, "R3 ready", 32'(card_rx_ready), 32'd1);
    @(posedge clk); #1 card_rx_valid = 0;
  endtask

  task automatic rd(input logic [1:0] sz, output logic [31:0] v);
    @(negedge clk); cpu_rd = 1; cpu_size = sz; #1 v = cpu_rdata;
    @(posedge clk); #1 cpu_rd = 0;
  endtask

  task automatic wr(input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk); cpu_wr = 1; cpu_size = sz; cpu_wdata = d;
    @(posedge clk); #1 cpu_wr = 0;
  endtask

  task automatic pop(output logic [7:0] d, output logic ok);
    @(negedge clk); card_tx_ready = 1; #1 ok = card_tx_valid; d = card_tx_data;
    @(posedge clk); #1 card_tx_ready = 0;
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0] b;
    logic ok;
    #1;
    chk({busy, rx_req, tx_req, data_done, prog_done, card_tx_valid, card_rx_ready} == 7'b0,
        "R1 reset", 32'({busy, rx_req, tx_req, data_done, prog_done, card_tx_valid, card_rx_ready}), 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1;

    // R2 zero length read transfer
    begin_xfer(0, 5, 0);
    chk(busy === 1'b1, "R2 busy", 32'(busy), 1);
    @(posedge clk); #1;
    chk(data_done && !busy && !prog_done, "R2 zero length done", {data_done, busy, prog_done}, 3'b100);

    // R2 product 3*2
    begin_xfer(0, 3, 2);
    for (int i = 0; i < 5; i++) push(8'(i));
    chk(busy && !data_done, "R2 still busy after 5", {busy, data_done}, 2'b10);
    push(8'h05);
    @(posedge clk); #1;
    chk(data_done && !prog_done && !busy, "R9 read end", {data_done, prog_done, busy}, 3'b100);
    chk(rx_req === 1'b1, "R7 set by byte", 32'(rx_req), 1);

    // R4 packing table
    begin_xfer(0, 12, 1);
    chk(rx_req === 1'b0, "R2 start clears", 32'(rx_req), 0);
    for (int i = 0; i < 12; i++) push(8'h10 + 8'(i));
    @(negedge clk);
    chk(card_rx_ready === 1'b0, "R3 no ready after end", 32'(card_rx_ready), 0);
    for (int k = 0; k < 6; k++) begin
      rd(RD_VEC[k][33:32], v);
      chk(v === RD_VEC[k][31:0], "R4 read packing", v, RD_VEC[k][31:0]);
      if (k == 0) chk(rx_req === 1'b0, "R7 cleared by read", 32'(rx_req), 0);
    end

    // R3/R11 full buffer and wrap
    begin_xfer(0, 40, 1);
    for (int i = 0; i < 32; i++) push(8'h40 + 8'(i));
    @(negedge clk);
    chk(busy && card_rx_ready === 1'b0, "R3 full holds off", 32'(card_rx_ready), 0);
    rd(2'd2, v);
    chk(v === 32'h40414243, "R4 first word", v, 32'h40414243);
    for (int i = 0; i < 4; i++) push(8'h60 + 8'(i));
    rd(2'd2, v);
    chk(v === 32'h44454647, "R11 order", v, 32'h44454647);
    for (int i = 0; i < 4; i++) push(8'h64 + 8'(i));
    for (int k = 0; k < 8; k++) begin
      logic [7:0] s;
      s = 8'h48 + 8'(4 * k);
      rd(2'd2, v);
      chk(v === {s, s + 8'd1, s + 8'd2, s + 8'd3}, "R11 wrap read", v, {s, s + 8'd1, s + 8'd2, s + 8'd3});
    end

    // R5/R6/R8/R9 write direction
    begin_xfer(1, 6, 1);
    chk(tx_req === 1'b0 && card_tx_valid === 1'b0, "R5 empty no valid", {tx_req, card_tx_valid}, 0);
    @(posedge clk); #1;
    chk(tx_req === 1'b1, "R8 request raised", 32'(tx_req), 1);
    wr(2'd2, 32'hA1A2A3A4);
    chk(tx_req === 1'b0, "R8 cleared by write", 32'(tx_req), 0);
    wr(2'd1, 32'h0000B1B2);
    begin
      logic [7:0] expv [6] = '{8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hB1, 8'hB2};
      for (int i = 0; i < 6; i++) begin
        pop(b, ok);
        chk(ok && b === expv[i], "R6 unpack order", {ok, b}, {1'b1, expv[i]});
      end
    end
    @(posedge clk); #1;
    chk(data_done && prog_done && !busy, "R9 write end", {data_done, prog_done, busy}, 3'b110);
    @(posedge clk); #1;
    chk(!data_done && !prog_done, "R9 single pulse", {data_done, prog_done}, 0);

    // R6 full, R10 flush
    begin_xfer(1, 64, 1);
    for (int k = 0; k < 8; k++)
      wr(2'd2, {8'(4 * k), 8'(4 * k + 1), 8'(4 * k + 2), 8'(4 * k + 3)});
    wr(2'd2, 32'hEEEEEEEE);
    for (int i = 0; i < 32; i++) begin
      pop(b, ok);
      chk(ok && b === 8'(i), "R6 full keep order", {ok, b}, {1'b1, 8'(i)});
    end
    @(negedge clk);
    chk(card_tx_valid === 1'b0, "R6 surplus dropped", 32'(card_tx_valid), 0);
    wr(2'd2, 32'h55667788);
    @(negedge clk); tx_flush = 1;
    @(posedge clk); #1 tx_flush = 0;
    chk(card_tx_valid === 1'b0, "R10 flush empties", 32'(card_tx_valid), 0);
    wr(2'd0, 32'h00000099);
    pop(b, ok);
    chk(ok && b === 8'h99, "R10 after flush", {ok, b}, {1'b1, 8'h99});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule